// File: doc/BRIEF.md
# FIFO DMA request controller

This block sits between the serial shifter of a peripheral and a DMA engine. It holds two byte-wide FIFOs of eight entries each. The shifter pushes received bytes into the receive FIFO and takes bytes to send from the transmit FIFO. The DMA engine drains the receive FIFO and fills the transmit FIFO, one byte per acknowledge. A request line for each direction tells the engine when service is wanted.

All control and status sits in one 32-bit register. Fill counts, flags and configuration are always visible on the read bus. A write applies the configuration fields, fires the write-one clear strobes and clears the sticky flags. The receive request rises once the receive FIFO reaches a programmed fill level. The transmit request stays up while there is room. Turning the transmit enable off removes the transmit request in the very cycle the write is presented.

Top module: `sfdc_top`

## Requirements
- R1: After reset the register reads 0x00000000, and both rx_dma_req and tx_dma_req are low.
- R2: Bits 27:24 give the number of bytes held in the receive FIFO, and bits 11:8 give the number held in the transmit FIFO (0 means empty, 8 means full). Both fields are read-only, so writes to them change nothing.
- R3: Each FIFO returns bytes in arrival order. rx_dma_data shows the oldest receive byte and tx_pop_data shows the oldest transmit byte.
- R4: Writing 1 to bit 20 empties the receive FIFO, and writing 1 to bit 4 empties the transmit FIFO. Writing 0 to these bits has no effect, and both always read 0. A clear wins over a push or pop to the same FIFO in the same cycle.
- R5: With the receive DMA enable (bit 31) set and threshold field N in bits 18:16, rx_dma_req is high exactly when the receive count is N+1 or more. With bit 31 clear, rx_dma_req stays low.
- R6: With the transmit DMA enable (bit 15) set, tx_dma_req is high exactly when the transmit count is below 8.
- R7: A register write with bit 15 equal to 0 forces tx_dma_req low in the same cycle the write is presented.
- R8: A push into a full FIFO (rx_push or tx_dma_ack) is dropped and leaves the count and the contents unchanged. It sets the sticky overflow flag in bit 30.
- R9: A pop from an empty FIFO (rx_dma_ack or tx_pop) is dropped and sets the sticky underflow flag in bit 29.
- R10: Writing 1 to bit 30 or bit 29 clears that flag, and writing 0 leaves it set. If a new event arrives in the same cycle as the clearing write, the flag stays set.
- R11: Reserved bits 28, 23:21, 19, 14:12 and 7:0 other than bit 4 read as 0, and writes to them have no effect.
- R12: A push and a pop to the same FIFO in one cycle are each judged against the count at the start of that cycle. On a full FIFO the pop proceeds and the push overflows, leaving 7 entries. On an empty FIFO the push proceeds and the pop underflows, leaving 1 entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, always valid |
| rx_push | input | 1 | Shifter pushes a received byte |
| rx_push_data | input | 8 | Byte from the shifter |
| tx_pop | input | 1 | Shifter takes a byte to send |
| tx_pop_data | output | 8 | Oldest transmit byte |
| rx_dma_req | output | 1 | Receive service request to the DMA engine |
| rx_dma_ack | input | 1 | DMA engine takes one receive byte |
| rx_dma_data | output | 8 | Oldest receive byte |
| tx_dma_req | output | 1 | Transmit service request to the DMA engine |
| tx_dma_ack | input | 1 | DMA engine delivers one transmit byte |
| tx_dma_data | input | 8 | Byte from the DMA engine |

## Verification
Every threshold code is swept against every receive fill level from empty to full. This exposes an off-by-one in the level encoding, which would raise the request one entry early or late. The transmit request is walked across all fill levels and probed in the middle of a disabling write. A design that acted on the stored enable would leave the request up for one extra cycle and draw a surplus byte. Overflow and underflow are driven alone, combined with an opposing operation in the same cycle, and combined with a flag-clearing write. A design that let a rejected push corrupt the head entry, or let the clear beat a fresh event, would show wrong data or a lost flag.

// File: rtl/sfdc_pkg.sv
package sfdc_pkg;
  localparam int RXEN_BIT  = 31;
  localparam int OVF_BIT   = 30;
  localparam int UDF_BIT   = 29;
  localparam int RXCNT_LSB = 24;
  localparam int RXCLR_BIT = 20;
  localparam int LVL_LSB   = 16;
  localparam int TXEN_BIT  = 15;
  localparam int TXCNT_LSB = 8;
  localparam int TXCLR_BIT = 4;
  localparam int FIELD_W   = 4;
  localparam int LVL_W     = 3;

  typedef struct packed {
    logic             rx_en;
    logic             tx_en;
    logic [LVL_W-1:0] lvl;
  } sfdc_cfg_t;
endpackage

// File: rtl/sfdc_fifo.sv
module sfdc_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          ovf_evt,
  output logic          udf_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_n;
  logic [PW-1:0] wr_ptr_q, wr_ptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign ovf_evt = push && full && !clr;
  assign udf_evt = pop && empty && !clr;

  always_comb begin
    rd_ptr_n = rd_ptr_q;
    wr_ptr_n = wr_ptr_q;
    cnt_n    = cnt_q;
    if (clr) begin
      rd_ptr_n = '0;
      wr_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (push_ok) wr_ptr_n = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_n = ptr_inc(rd_ptr_q);
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_n;
      wr_ptr_q <= wr_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  assign head_data = mem[rd_ptr_q];
  assign count     = cnt_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R4
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && count == CW'(DEPTH)) |=> $stable(count));
  // R12
  both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clr && count != '0 && count != CW'(DEPTH)) |=> $stable(count));
endmodule

// File: rtl/sfdc_csr.sv
module sfdc_csr
  import sfdc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [31:0]     wdata,
  input  logic [CW-1:0]   rx_cnt,
  input  logic [CW-1:0]   tx_cnt,
  input  logic            ovf_evt,
  input  logic            udf_evt,
  output sfdc_cfg_t       cfg,
  output logic            tx_en_live,
  output logic            rx_clr,
  output logic            tx_clr,
  output logic [31:0]     rdata
);
  sfdc_cfg_t cfg_q, cfg_n;
  logic      ovf_q, ovf_n, udf_q, udf_n;
  logic      unused_wbits;

  assign unused_wbits = ^{wdata[28:21], wdata[19], wdata[14:5], wdata[3:0]};

  always_comb begin
    cfg_n = cfg_q;
    if (wr) begin
      cfg_n.rx_en = wdata[RXEN_BIT];
      cfg_n.tx_en = wdata[TXEN_BIT];
      cfg_n.lvl   = wdata[LVL_LSB +: LVL_W];
    end
    ovf_n = ovf_evt || (ovf_q && !(wr && wdata[OVF_BIT]));
    udf_n = udf_evt || (udf_q && !(wr && wdata[UDF_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      ovf_q <= ovf_n;
      udf_q <= udf_n;
    end
  end

  assign cfg        = cfg_q;
  assign tx_en_live = wr ? wdata[TXEN_BIT] : cfg_q.tx_en;
  assign rx_clr     = wr && wdata[RXCLR_BIT];
  assign tx_clr     = wr && wdata[TXCLR_BIT];

  always_comb begin
    rdata = '0;
    rdata[RXEN_BIT]                = cfg_q.rx_en;
    rdata[OVF_BIT]                 = ovf_q;
    rdata[UDF_BIT]                 = udf_q;
    rdata[RXCNT_LSB +: FIELD_W]    = FIELD_W'(rx_cnt);
    rdata[LVL_LSB +: LVL_W]        = cfg_q.lvl;
    rdata[TXEN_BIT]                = cfg_q.tx_en;
    rdata[TXCNT_LSB +: FIELD_W]    = FIELD_W'(tx_cnt);
  end

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> rdata[OVF_BIT]);
  // R9
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> rdata[UDF_BIT]);
  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[OVF_BIT] && !wr) |=> rdata[OVF_BIT]);
endmodule

// File: rtl/sfdc_req.sv
module sfdc_req
  import sfdc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = (CW > LVL_W + 1) ? CW : LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tx_en_live,
  input  logic [LVL_W-1:0] lvl,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [CW-1:0]    tx_cnt,
  output logic             rx_req,
  output logic             tx_req
);
  logic [TW-1:0] need;

  assign need   = TW'(lvl) + TW'(1);
  assign rx_req = rx_en && (TW'(rx_cnt) >= need);
  assign tx_req = tx_en_live && (tx_cnt < CW'(DEPTH));

  // R5
  rx_req_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_cnt != '0));
  // R6
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH)) |-> !tx_req);
endmodule

// File: rtl/sfdc_top.sv
module sfdc_top
  import sfdc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  output logic          rx_dma_req,
  input  logic          rx_dma_ack,
  output logic [DW-1:0] rx_dma_data,
  output logic          tx_dma_req,
  input  logic          tx_dma_ack,
  input  logic [DW-1:0] tx_dma_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_ovf, rx_udf, tx_ovf, tx_udf;
  logic          rx_clr, tx_clr, tx_en_live;
  sfdc_cfg_t     cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  sfdc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n_s), .clr(rx_clr),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_dma_ack),
    .head_data(rx_dma_data), .count(rx_cnt),
    .ovf_evt(rx_ovf), .udf_evt(rx_udf)
  );

  sfdc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n_s), .clr(tx_clr),
    .push(tx_dma_ack), .push_data(tx_dma_data), .pop(tx_pop),
    .head_data(tx_pop_data), .count(tx_cnt),
    .ovf_evt(tx_ovf), .udf_evt(tx_udf)
  );

  sfdc_csr #(.CW(CW)) u_csr (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .wdata(reg_wdata),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .ovf_evt(rx_ovf | tx_ovf), .udf_evt(rx_udf | tx_udf),
    .cfg(cfg), .tx_en_live(tx_en_live),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .rdata(reg_rdata)
  );

  sfdc_req #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n_s),
    .rx_en(cfg.rx_en), .tx_en_live(tx_en_live), .lvl(cfg.lvl),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_req(rx_dma_req), .tx_req(tx_dma_req)
  );

  // R7
  tx_kill_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && !reg_wdata[TXEN_BIT]) |-> !tx_dma_req);
  // R5
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !reg_rdata[RXEN_BIT] |-> !rx_dma_req);
  // R11
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rdata[28] == 1'b0) && (reg_rdata[RXCLR_BIT] == 1'b0) && (reg_rdata[TXCLR_BIT] == 1'b0));
endmodule

// File: tb/sfdc_top_test.sv
module sfdc_top_test;
  logic        clk, rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_push, tx_pop, rx_dma_ack, tx_dma_ack;
  logic [7:0]  rx_push_data, tx_pop_data, rx_dma_data, tx_dma_data;
  logic        rx_dma_req, tx_dma_req;
  int          checks = 0;
  int          errors = 0;

  sfdc_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_dma_req(rx_dma_req),
    .rx_dma_ack(rx_dma_ack), .rx_dma_data(rx_dma_data), .tx_dma_req(tx_dma_req),
    .tx_dma_ack(tx_dma_ack), .tx_dma_data(tx_dma_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = 0; rx_push = 0; rx_push_data = 0; tx_pop = 0;
    rx_dma_ack = 0; tx_dma_ack = 0; tx_dma_data = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle(); #1;
  endtask

  task automatic wreg(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; step();
  endtask

  task automatic rxp(input logic [7:0] b);
    rx_push = 1; rx_push_data = b; step();
  endtask

  task automatic txa(input logic [7:0] b);
    tx_dma_ack = 1; tx_dma_data = b; step();
  endtask

  function automatic logic [31:0] rxc(); return (reg_rdata >> 24) & 32'hF; endfunction
  function automatic logic [31:0] txc(); return (reg_rdata >> 8) & 32'hF; endfunction

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(); rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    // R1
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 rx_req", {31'd0, rx_dma_req}, 0);
    chk("R1 tx_req", {31'd0, tx_dma_req}, 0);

    // R11 reserved bits and R2 read-only counts
    wreg(32'h1FE8_7FEF);
    chk("R11 reserved read 0", reg_rdata, 0);
    chk("R2 count fields read-only", rxc() | txc(), 0);

    // R2 fill, R5 disabled, R8 overflow
    for (int n = 0; n < 9; n++) begin
      chk("R2 rx count", rxc(), n);
      chk("R5 rx_req off while disabled", {31'd0, rx_dma_req}, 0);
      if (n < 8) rxp(8'(n));
    end
    chk("R8 ovf clear before", reg_rdata[30], 0);
    rxp(8'hEE);
    chk("R8 rx count held", rxc(), 8);
    chk("R8 ovf set", reg_rdata[30], 1);
    chk("R8 head intact", rx_dma_data, 8'h00);

    // R5 threshold sweep
    for (int lvl = 0; lvl < 8; lvl++) begin
      wreg(32'h8000_0000 | (lvl << 16) | (1 << 20));
      for (int n = 0; n < 9; n++) begin
        chk($sformatf("R5 lvl%0d cnt%0d", lvl, n), {31'd0, rx_dma_req}, (n >= lvl + 1) ? 1 : 0);
        chk("R2 rx count sweep", rxc(), n);
        if (n < 8) rxp(8'(lvl * 16 + n));
      end
    end

    // R3 order, R9 underflow
    for (int i = 0; i < 8; i++) begin
      chk("R3 rx order", rx_dma_data, 8'h70 + 8'(i));
      rx_dma_ack = 1; step();
    end
    chk("R9 udf clear before", reg_rdata[29], 0);
    rx_dma_ack = 1; step();
    chk("R9 udf set", reg_rdata[29], 1);
    chk("R9 rx count 0", rxc(), 0);

    // R10 write-one-to-clear
    wreg(32'h4000_0000);
    chk("R10 ovf cleared", reg_rdata[30], 0);
    chk("R10 udf kept", reg_rdata[29], 1);
    wreg(32'h2000_0000);
    chk("R10 udf cleared", reg_rdata[29], 0);
    rx_dma_ack = 1; reg_wr = 1; reg_wdata = 32'h2000_0000; step();
    chk("R10 event beats clear", reg_rdata[29], 1);
    wreg(32'h2000_0000);

    // R4 clears
    rxp(8'h11); rxp(8'h22); rxp(8'h33);
    wreg(32'h0);
    chk("R4 write 0 no clear", rxc(), 3);
    chk("R4 clr bit reads 0", reg_rdata[20], 0);
    rx_push = 1; rx_push_data = 8'h55; reg_wr = 1; reg_wdata = 32'h0010_0000; step();
    chk("R4 rx clear wins", rxc(), 0);
    rxp(8'h44);
    chk("R4 head after clear", rx_dma_data, 8'h44);
    wreg(32'h0010_0000);

    // R6 tx request sweep
    wreg(32'h0000_8000);
    for (int n = 0; n < 9; n++) begin
      chk($sformatf("R6 tx_req cnt%0d", n), {31'd0, tx_dma_req}, (n < 8) ? 1 : 0);
      chk("R2 tx count", txc(), n);
      if (n < 8) txa(8'h30 + 8'(n));
    end
    chk("R8 ovf clear before tx", reg_rdata[30], 0);
    txa(8'hFF);
    chk("R8 tx count held", txc(), 8);
    chk("R8 tx ovf", reg_rdata[30], 1);
    for (int i = 0; i < 8; i++) begin
      chk("R3 tx order", tx_pop_data, 8'h30 + 8'(i));
      tx_pop = 1; step();
    end
    tx_pop = 1; step();
    chk("R9 tx udf", reg_rdata[29], 1);
    wreg(32'h6000_8000);
    chk("R10 both cleared", reg_rdata[30:29], 0);

    // R7 same-cycle disable
    chk("R7 tx_req before", {31'd0, tx_dma_req}, 1);
    reg_wr = 1; reg_wdata = 32'h0000_8000; #1;
    chk("R7 enabled write keeps req", {31'd0, tx_dma_req}, 1);
    reg_wdata = 32'h0; #1;
    chk("R7 req drops same cycle", {31'd0, tx_dma_req}, 0);
    step();
    chk("R7 req stays low", {31'd0, tx_dma_req}, 0);
    chk("R7 enable reads 0", reg_rdata[15], 0);

    // R4 tx clear with push same cycle
    wreg(32'h0000_8000);
    txa(8'h01); txa(8'h02); txa(8'h03);
    chk("R2 tx three", txc(), 3);
    tx_dma_ack = 1; tx_dma_data = 8'h09; reg_wr = 1; reg_wdata = 32'h0000_8010; step();
    chk("R4 tx clear wins", txc(), 0);
    chk("R4 tx req after clear", {31'd0, tx_dma_req}, 1);

    // R12 simultaneous push and pop
    wreg(32'h6010_0000);
    for (int i = 0; i < 8; i++) rxp(8'h50 + 8'(i));
    rx_push = 1; rx_push_data = 8'h99; rx_dma_ack = 1; step();
    chk("R12 full count", rxc(), 7);
    chk("R12 full ovf", reg_rdata[30], 1);
    chk("R12 full head", rx_dma_data, 8'h51);
    wreg(32'h6010_0000);
    rx_push = 1; rx_push_data = 8'h77; rx_dma_ack = 1; step();
    chk("R12 empty count", rxc(), 1);
    chk("R12 empty udf", reg_rdata[29], 1);
    chk("R12 empty head", rx_dma_data, 8'h77);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule